// File: doc/BRIEF.md
# Self-Recovering C-Element Latch Model

This block is a cycle-stepped, synthesizable behavioural model of a radiation-hardened storage latch. The stored bit is held in a closed mesh of sixteen two-input inverting C-elements, organised as four stages of four lanes. Every element of a stage reads two neighbouring elements of the previous stage: lane j reads lanes j and j+1, wrapping around. An element drives the inverse of its inputs when they agree and keeps its last output when they disagree. A disagreement therefore stops at the next stage, and the loop then rewrites the corrupted nodes.

Each rising edge of the evaluation clock is one settling step. The transparent input selects the mode. When it is high, the four first-stage nodes, which include the output, are loaded straight from `d`, and the rest of the mesh settles from that value within the same step. When it is low, the fourth stage drives the first stage and closes the loop. The upset mask port XORs any chosen set of node registers for one step. A bench can use it to hit the latch with single, double or triple upsets and watch the mesh repair itself. A per-node error vector reports every node whose value does not match the polarity that the stored bit implies.

Top module: `rhl_latch`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the mesh is set to the state for a stored 0. After that edge `q` is 0 and `node_err` is all zeros.
- R2: At an edge with `transparent` high and a zero mask, the latch captures `d`. From that edge on, `q` equals the captured value and `node_err` is all zeros.
- R3: At an edge with `transparent` low and a zero mask, on a clean mesh, `q` keeps the stored bit and `node_err` stays zero whatever `d` does.
- R4: Node numbering is bit = 4*stage + lane. Stage 0 lanes are N1, N2, N3 and the output (bit 3). Stage 1 holds N4..N7 at bits 4..7, stage 2 holds N8..N11 at bits 8..11, and stage 3 holds N12..N15 at bits 12..15. `node_err[i]` is 1 when node i differs from the stored bit (even stage) or from its inverse (odd stage). On a clean mesh in hold mode, the edge after a nonzero mask leaves `node_err` equal to that mask.
- R5: Each element follows the hold-on-disagree rule inside one step. After upsets on {N1,N2} (mask 0x0003), the next step leaves only N4 wrong (`node_err` = 0x0010). After {N1,N2,N3} (mask 0x0007), the next step leaves N4, N5 and N8 wrong (0x0130). After {N8,N9,N11} (mask 0x0B00), the next step leaves no node wrong.
- R6: After any hold-mode upset of one, two or three nodes, `node_err` is back to zero within 8 evaluation steps, and the stored bit is unchanged.
- R7: During recovery from any upset of at most three nodes, `q` never leaves the stored value, except in the upset step itself when bit 3 is in the mask. In that case `q` is inverted for exactly that one step.
- R8: A mask applied at an edge where the latch is transparent acts on the freshly captured value. After that edge `q` = `d` XOR mask bit 3 and `node_err` = mask. The next hold step repairs the mesh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Evaluation clock, one settling step per rising edge |
| rst | input | 1 | Synchronous active-high reset to a stored 0 |
| transparent | input | 1 | 1: load from `d`; 0: hold through the mesh loop |
| d | input | 1 | Data bit to be captured |
| upset_mask | input | 16 | Per-node flip request for this step, numbered as in R4 |
| q | output | 1 | Latch output (first-stage lane 3) |
| node_err | output | 16 | Per-node polarity mismatch flags, numbered as in R4 |

## Verification
Two things can land in the same step here: an upset and the capture of a new value, or an upset and the settling that repairs an earlier one. The bench drives a mask together with a transparent write, and checks that the flips sit on top of the new value and are repaired on the next hold step. It also sweeps every mask of one to three nodes, for both stored values, with `d` toggling during hold. In each case it judges the error vector on the step after the upset, whether `q` stays steady through every later step, and whether the mesh is clean after eight steps.

// File: rtl/rhl_pkg.sv
package rhl_pkg;

    // Mesh geometry: STAGES must be even so the inverting loop closes on itself
    localparam int unsigned STAGES     = 4;
    localparam int unsigned LANES      = 4;
    localparam int unsigned NODES      = STAGES * LANES;
    localparam int unsigned OUT_LANE   = LANES - 1;
    localparam int unsigned RECOVER_MAX = 8;

    typedef logic [LANES-1:0]            lane_vec_t;
    typedef lane_vec_t [STAGES-1:0]      mesh_t;
    typedef logic [NODES-1:0]            node_mask_t;

    // Inverting two-input C-element: invert on agreement, keep on disagreement
    function automatic logic celem_eval(input logic a, input logic b, input logic prev);
        return (a == b) ? ~a : prev;
    endfunction

    // Consistent mesh contents for a given stored bit
    function automatic mesh_t polarity_mesh(input logic stored);
        mesh_t m;
        for (int s = 0; s < int'(STAGES); s++) begin
            m[s] = (s % 2 == 0) ? {LANES{stored}} : {LANES{~stored}};
        end
        return m;
    endfunction

endpackage

// File: rtl/rhl_celem.sv
module rhl_celem (
    input  logic in_a,
    input  logic in_b,
    input  logic held,
    output logic out_n
);
    import rhl_pkg::*;

    always_comb begin
        out_n = celem_eval(in_a, in_b, held);
    end

endmodule

// File: rtl/rhl_stage.sv
module rhl_stage
    import rhl_pkg::*;
(
    input  lane_vec_t src,
    input  lane_vec_t cur,
    output lane_vec_t nxt
);

    // Lane j reads lanes j and j+1 of the previous stage, wrapping around
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        rhl_celem u_celem (
            .in_a  (src[j]),
            .in_b  (src[(j + 1) % LANES]),
            .held  (cur[j]),
            .out_n (nxt[j])
        );
    end

endmodule

// File: rtl/rhl_polarity.sv
module rhl_polarity
    import rhl_pkg::*;
(
    input  mesh_t      nodes,
    input  logic       stored,
    output node_mask_t mismatch
);

    always_comb begin
        mismatch = nodes ^ polarity_mesh(stored);
    end

endmodule

// File: rtl/rhl_latch.sv
module rhl_latch
    import rhl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             transparent,
    input  logic             d,
    input  logic [NODES-1:0] upset_mask,
    output logic             q,
    output logic [NODES-1:0] node_err
);

    mesh_t     node_q;
    mesh_t     next_mesh;
    logic      stored_q;
    lane_vec_t ripple [STAGES];
    lane_vec_t closed0;

    // Stage 0 as seen by the mesh this step: the pass path in transparent mode
    assign ripple[0] = transparent ? {LANES{d}} : node_q[0];

    // Stages 1..STAGES-1 settle in order within one step
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        rhl_stage u_stage (
            .src (ripple[s-1]),
            .cur (node_q[s]),
            .nxt (ripple[s])
        );
    end

    // Clock-gated loop-closing stage, only effective while holding
    rhl_stage u_close (
        .src (ripple[STAGES-1]),
        .cur (node_q[0]),
        .nxt (closed0)
    );

    always_comb begin
        next_mesh[0] = transparent ? {LANES{d}} : closed0;
        for (int s = 1; s < int'(STAGES); s++) begin
            next_mesh[s] = ripple[s];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            node_q   <= polarity_mesh(1'b0);
            stored_q <= 1'b0;
        end else begin
            node_q <= next_mesh ^ upset_mask;
            if (transparent) begin
                stored_q <= d;
            end
        end
    end

    rhl_polarity u_pol (
        .nodes    (node_q),
        .stored   (stored_q),
        .mismatch (node_err)
    );

    assign q = node_q[0][OUT_LANE];

endmodule

// File: rtl/rhl_latch_chk.sv
module rhl_latch_chk
    import rhl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             transparent,
    input logic             d,
    input logic [NODES-1:0] upset_mask,
    input logic             q,
    input logic [NODES-1:0] node_err
);

    logic [3:0] settle_cnt;
    logic       armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            settle_cnt <= '0;
            armed      <= 1'b0;
        end else if (transparent || (upset_mask != '0)) begin
            settle_cnt <= '0;
            armed      <= !transparent && ($countones(upset_mask) <= 3);
        end else if (node_err != '0) begin
            settle_cnt <= settle_cnt + {3'b000, (settle_cnt != 4'hF)};
        end else begin
            settle_cnt <= '0;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (q == 1'b0) && (node_err == '0));

    // R2
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (transparent && upset_mask == '0) |=> (q == $past(d)) && (node_err == '0));

    // R3
    hold_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (!transparent && upset_mask == '0 && node_err == '0) |=> $stable(q) && (node_err == '0));

    // R4
    upset_map_chk: assert property (@(posedge clk) disable iff (rst)
        (!transparent && upset_mask != '0 && node_err == '0) |=> (node_err == $past(upset_mask)));

    // R7
    q_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (!transparent && node_err == '0 && !upset_mask[OUT_LANE]
         && $countones(upset_mask) <= 3) |=> $stable(q));

    // R6
    recover_window_chk: assert property (@(posedge clk) disable iff (rst)
        armed |-> (settle_cnt <= 4'(RECOVER_MAX)));

endmodule

bind rhl_latch rhl_latch_chk u_chk (.*);

// File: tb/rhl_latch_tb.sv
module rhl_latch_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        transparent;
    logic        d;
    logic [15:0] upset_mask;
    logic        q;
    logic [15:0] node_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #10ns clk = ~clk;

    rhl_latch dut_i (
        .clk         (clk),
        .rst         (rst),
        .transparent (transparent),
        .d           (d),
        .upset_mask  (upset_mask),
        .q           (q),
        .node_err    (node_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, return at the next falling edge
    task automatic tick(input logic tr, input logic dv, input logic [15:0] m);
        transparent = tr;
        d           = dv;
        upset_mask  = m;
        @(negedge clk);
    endtask

    // Hold-mode upset and recovery for one stored value and mask
    task automatic sweep_one(input logic sb, input logic [15:0] m);
        logic q_ok;
        tick(1'b1, sb, 16'h0);
        tick(1'b0, ~sb, m);
        chk("R4 error map after upset", 32'(node_err), 32'(m));
        q_ok = (q === (m[3] ? ~sb : sb));
        for (int i = 0; i < 8; i++) begin
            tick(1'b0, 1'($urandom % 2), 16'h0);
            if (q !== sb) q_ok = 1'b0;
        end
        chk("R7 q steady during recovery", 32'(q_ok), 32'd1);
        chk("R6 clean within 8 steps", 32'(node_err), 32'h0);
        chk("R3 stored bit kept", 32'(q), 32'(sb));
    endtask

    initial begin
        logic dv;
        logic [15:0] m;
        void'($urandom(32'd20211010));
        rst = 1'b1; transparent = 1'b0; d = 1'b1; upset_mask = 16'h0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset q", 32'(q), 32'h0);
        chk("R1 reset node_err", 32'(node_err), 32'h0);
        rst = 1'b0;

        // R2 capture of both values
        tick(1'b1, 1'b1, 16'h0);
        chk("R2 capture 1 q", 32'(q), 32'h1);
        chk("R2 capture 1 clean", 32'(node_err), 32'h0);
        tick(1'b1, 1'b0, 16'h0);
        chk("R2 capture 0 q", 32'(q), 32'h0);

        // R3 hold ignores d
        tick(1'b1, 1'b1, 16'h0);
        for (int i = 0; i < 4; i++) tick(1'b0, 1'(i % 2), 16'h0);
        chk("R3 hold ignores d q", 32'(q), 32'h1);
        chk("R3 hold ignores d clean", 32'(node_err), 32'h0);

        // R5 directed settling steps
        tick(1'b0, 1'b0, 16'h0003);
        chk("R5 pair N1N2 upset", 32'(node_err), 32'h0003);
        tick(1'b0, 1'b0, 16'h0);
        chk("R5 pair N1N2 leaves N4", 32'(node_err), 32'h0010);
        tick(1'b0, 1'b0, 16'h0);
        chk("R5 pair N1N2 clean", 32'(node_err), 32'h0);
        tick(1'b0, 1'b1, 16'h0007);
        tick(1'b0, 1'b1, 16'h0);
        chk("R5 triple N1N2N3 leaves N4N5N8", 32'(node_err), 32'h0130);
        chk("R7 triple N1N2N3 q", 32'(q), 32'h1);
        tick(1'b0, 1'b0, 16'h0B00);
        tick(1'b0, 1'b0, 16'h0);
        chk("R5 triple N8N9N11 repaired", 32'(node_err), 32'h0);
        chk("R7 triple N8N9N11 q", 32'(q), 32'h1);

        // R8 upset together with a write
        tick(1'b1, 1'b0, 16'h0008);
        chk("R8 write plus upset q", 32'(q), 32'h1);
        chk("R8 write plus upset err", 32'(node_err), 32'h0008);
        tick(1'b0, 1'b1, 16'h0);
        chk("R8 repaired q", 32'(q), 32'h0);
        chk("R8 repaired err", 32'(node_err), 32'h0);

        // Exhaustive sweep of masks with one, two or three nodes
        for (int v = 0; v < 2; v++) begin
            for (int a = 0; a < 16; a++) begin
                sweep_one(1'(v), 16'(1) << a);
                for (int b = a + 1; b < 16; b++) begin
                    sweep_one(1'(v), (16'(1) << a) | (16'(1) << b));
                    for (int c = b + 1; c < 16; c++) begin
                        sweep_one(1'(v), (16'(1) << a) | (16'(1) << b) | (16'(1) << c));
                    end
                end
            end
        end

        // Random mix of writes, holds and small upsets
        for (int it = 0; it < 300; it++) begin
            dv = 1'($urandom % 2);
            case ($urandom % 3)
                0: begin
                    tick(1'b1, dv, 16'h0);
                    chk("R2 random capture", 32'(q), 32'(dv));
                end
                1: begin
                    tick(1'b1, dv, 16'h0);
                    tick(1'b0, ~dv, 16'h0);
                    chk("R3 random hold", 32'(q), 32'(dv));
                end
                default: begin
                    m = 16'(1) << ($urandom % 16);
                    m = m | (($urandom % 2 == 1) ? (16'(1) << ($urandom % 16)) : 16'h0);
                    m = m | (($urandom % 2 == 1) ? (16'(1) << ($urandom % 16)) : 16'h0);
                    sweep_one(dv, m);
                end
            endcase
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule